// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits beside the byte-load path of a page-programmed non-volatile memory. It watches each completed byte load, given as a 15-bit address and an 8-bit data value, and tells the page buffer in the same cycle whether that load may be stored. It also keeps a protection flag. Only a separate power-on initialisation input clears that flag. The ordinary reset leaves it alone, so it behaves like a fuse that outlives power cycles.

When protection is off, every ordinary write is stored. When protection is on, a write is stored only inside a window that an unlock sequence opens. The unlock sequence is three keyed writes, and it always turns protection on. The window then accepts one page load at any address. It closes when the programming timer reports that the page has been programmed, and protection is back in force. A six-write erase sequence requests one programming cycle. When that cycle finishes, protection is off. Keyed writes are consumed and never stored. A write that breaks a partly matched sequence sends the matcher back to idle.

Top module: `wprot_cmd_seq`

## Requirements
- R1: After power-on initialisation, `prot_on` is 0. While it stays 0, any load that is not a command write has `ld_permit` high in the same cycle as `ld_valid`.
- R2: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 form the unlock sequence. Completing it sets `prot_on` on the next clock edge.
- R3: After the unlock sequence, every load at any address is permitted. This lasts until `prog_done` is seen, after which an ordinary load is refused.
- R4: With `prot_on` high and no window open, ordinary loads have `ld_permit` low.
- R5: The erase sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. `prog_start` is high for exactly the one cycle after the sixth write. `prot_on` stays high until `prog_done`, and it is 0 on the next clock edge after that.
- R6: Between the erase request and its `prog_done`, every load has `ld_permit` low.
- R7: A write that does not continue a partly matched sequence returns the matcher to idle. That write is stored when protection is off and discarded when it is on. If the breaking write equals the first keyed write, it starts a new sequence.
- R8: A load that continues or starts a sequence never has `ld_permit` high, even with protection off. The exception is a load made inside an open window.
- R9: `rst_n` low clears the matcher, the window and any pending erase, but does not change `prot_on`.
- R10: `por_n` low clears `prot_on` and all other state.
- R11: Using the unlock sequence while protection is off also sets `prot_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; keeps protection flag |
| por_n | input | 1 | Synchronous active-low power-on initialisation; clears protection |
| ld_valid | input | 1 | One completed byte load this cycle |
| ld_addr | input | 15 | Byte load address |
| ld_data | input | 8 | Byte load data |
| prog_done | input | 1 | Programming timer finished a cycle |
| ld_permit | output | 1 | This load may be stored (combinational) |
| prog_start | output | 1 | One-cycle request for an erase programming cycle |
| prot_on | output | 1 | Current protection state |

## Verification
If the sequence stage is wrong, the flaw shows up at the latest on the keyed write that follows. That write's `ld_permit` comes out wrong in its own cycle, or `prot_on` or `prog_start` does not move on the next edge. A stuck window or a stuck pending erase shows up on the first ordinary load after `prog_done`, which would then be permitted or refused in error. A protection flag that reset wrongly touches differs on `prot_on` right after `rst_n` is released.

// File: rtl/wprot_pkg.sv
// Shared types for the write-protect sequencer.
// Assumes at most six keyed steps in any command sequence.
package wprot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S1   = 3'd1,
        ST_S2   = 3'd2,
        ST_S3   = 3'd3,
        ST_S4   = 3'd4,
        ST_S5   = 3'd5
    } stage_e;
    localparam int NSTEP     = 6;
    localparam int LOCK_STEP = 2;
endpackage

// File: rtl/wprot_seq_match.sv
// Keyed-sequence matcher. Tracks how far the incoming loads have gone through
// the erase/unlock command scripts and flags loads that belong to a script.
// Assumes at most one load per cycle; match_en low freezes the stage.
module wprot_seq_match
    import wprot_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8,
    parameter logic [AW-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [AW-1:0] KEY_ADDR_B = 15'h2AAA,
    parameter logic [DW-1:0] KEY_DATA_A = 8'hAA,
    parameter logic [DW-1:0] KEY_DATA_B = 8'h55,
    parameter logic [DW-1:0] LOCK_DATA  = 8'hA0,
    parameter logic [DW-1:0] ERASE_DATA = 8'h80,
    parameter logic [DW-1:0] CLEAR_DATA = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          ld_valid,
    input  logic          match_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic          cmd_hit,
    output logic          lock_done,
    output logic          clear_done
);
    localparam logic [AW-1:0] SEQ_A [NSTEP] =
        '{KEY_ADDR_A, KEY_ADDR_B, KEY_ADDR_A, KEY_ADDR_A, KEY_ADDR_B, KEY_ADDR_A};
    localparam logic [DW-1:0] SEQ_D [NSTEP] =
        '{KEY_DATA_A, KEY_DATA_B, ERASE_DATA, KEY_DATA_A, KEY_DATA_B, CLEAR_DATA};
    localparam int LAST = NSTEP - 1;

    logic [NSTEP-1:0] step_eq;
    logic             lock_eq;
    logic             act;
    logic             expect_eq;
    logic             at_lock;
    stage_e           stage_q;
    stage_e           stage_d;

    // One comparator per script step against the current load
    for (genvar i = 0; i < NSTEP; i++) begin : g_step
        assign step_eq[i] = (ld_addr == SEQ_A[i]) && (ld_data == SEQ_D[i]);
    end

    // Alternate third step that ends the unlock script
    assign lock_eq = (ld_addr == SEQ_A[LOCK_STEP]) && (ld_data == LOCK_DATA);

    // Classify the current load against the expected step
    always_comb begin
        act        = ld_valid && match_en;
        expect_eq  = step_eq[stage_q];
        at_lock    = (stage_q == ST_S2) && lock_eq;
        lock_done  = act && at_lock;
        clear_done = act && (stage_q == ST_S5) && step_eq[LAST];
        cmd_hit    = act && (expect_eq || at_lock || step_eq[0]);
    end

    // Next stage: advance, finish, restart on the first key, or abort
    always_comb begin
        stage_d = stage_q;
        if (act) begin
            if (lock_done || clear_done) begin
                stage_d = ST_IDLE;
            end else if (expect_eq) begin
                stage_d = stage_e'(stage_q + 3'd1);
            end else if (step_eq[0]) begin
                stage_d = ST_S1;
            end else begin
                stage_d = ST_IDLE;
            end
        end
    end

    // Stage register, cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            stage_q <= ST_IDLE;
        end else begin
            stage_q <= stage_d;
        end
    end
endmodule

// File: rtl/wprot_state.sv
// Protection state keeper: the persistent protection flag, the unlock window
// and the pending erase. Only por_n clears the flag; rst_n clears the rest.
// Assumes prog_done is a single-cycle pulse from the programming timer.
module wprot_state (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic lock_done,
    input  logic clear_done,
    input  logic prog_done,
    output logic prot_on,
    output logic window_open,
    output logic erase_busy,
    output logic prog_start
);
    logic prot_q;
    logic win_q;
    logic pend_q;
    logic start_q;

    // Persistent flag: set by unlock, cleared by a finished erase or power-on
    always_ff @(posedge clk) begin
        if (!por_n) begin
            prot_q <= 1'b0;
        end else if (rst_n) begin
            if (lock_done) begin
                prot_q <= 1'b1;
            end else if (pend_q && prog_done) begin
                prot_q <= 1'b0;
            end
        end
    end

    // Unlock window: opens on unlock, closes when a page has been programmed
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            win_q <= 1'b0;
        end else if (lock_done) begin
            win_q <= 1'b1;
        end else if (prog_done) begin
            win_q <= 1'b0;
        end
    end

    // Pending erase: waits for its programming cycle to finish
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            pend_q <= 1'b0;
        end else if (clear_done) begin
            pend_q <= 1'b1;
        end else if (prog_done) begin
            pend_q <= 1'b0;
        end
    end

    // Single-cycle request to start the erase programming cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= clear_done;
        end
    end

    assign prot_on     = prot_q;
    assign window_open = win_q;
    assign erase_busy  = pend_q;
    assign prog_start  = start_q;
endmodule

// File: rtl/wprot_cmd_seq.sv
// Top of the software write-protect sequencer. Matches keyed command writes,
// keeps the protection state and qualifies every byte load in its own cycle.
// Assumes loads arrive as single-cycle ld_valid pulses with stable address/data.
module wprot_cmd_seq #(
    parameter int AW = 15,
    parameter int DW = 8,
    parameter logic [AW-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [AW-1:0] KEY_ADDR_B = 15'h2AAA,
    parameter logic [DW-1:0] KEY_DATA_A = 8'hAA,
    parameter logic [DW-1:0] KEY_DATA_B = 8'h55,
    parameter logic [DW-1:0] LOCK_DATA  = 8'hA0,
    parameter logic [DW-1:0] ERASE_DATA = 8'h80,
    parameter logic [DW-1:0] CLEAR_DATA = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          prog_done,
    output logic          ld_permit,
    output logic          prog_start,
    output logic          prot_on
);
    logic cmd_hit;
    logic lock_done;
    logic clear_done;
    logic window_open;
    logic erase_busy;
    logic match_en;

    // Matching pauses while a window is open or an erase is pending
    assign match_en = !window_open && !erase_busy;

    wprot_seq_match #(
        .AW(AW), .DW(DW),
        .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B),
        .KEY_DATA_A(KEY_DATA_A), .KEY_DATA_B(KEY_DATA_B),
        .LOCK_DATA(LOCK_DATA), .ERASE_DATA(ERASE_DATA), .CLEAR_DATA(CLEAR_DATA)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .ld_valid   (ld_valid),
        .match_en   (match_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .cmd_hit    (cmd_hit),
        .lock_done  (lock_done),
        .clear_done (clear_done)
    );

    wprot_state u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .lock_done   (lock_done),
        .clear_done  (clear_done),
        .prog_done   (prog_done),
        .prot_on     (prot_on),
        .window_open (window_open),
        .erase_busy  (erase_busy),
        .prog_start  (prog_start)
    );

    // Load qualifier: never while erasing, always in a window, else data only when open
    always_comb begin
        ld_permit = ld_valid && !erase_busy && (window_open || (!cmd_hit && !prot_on));
    end
endmodule

// File: rtl/wprot_cmd_seq_chk.sv
// Property checker for the write-protect sequencer, bound to the top module.
module wprot_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic por_n,
    input logic ld_valid,
    input logic prog_done,
    input logic ld_permit,
    input logic prog_start,
    input logic prot_on,
    input logic window_open,
    input logic erase_busy
);
    // R3: every load inside an open window is permitted
    assert_window_permits_R3: assert property (@(posedge clk)
        disable iff (!rst_n || !por_n) (window_open && ld_valid) |-> ld_permit);

    // R6: nothing is stored while an erase is pending
    assert_busy_blocks_R6: assert property (@(posedge clk)
        disable iff (!rst_n || !por_n) erase_busy |-> !ld_permit);

    // R5: erase request lasts one cycle and only while protected
    assert_start_pulse_R5: assert property (@(posedge clk)
        disable iff (!rst_n || !por_n) prog_start |=> !prog_start);
    assert_start_protected_R5: assert property (@(posedge clk)
        disable iff (!rst_n || !por_n) prog_start |-> prot_on);

    // R5: protection drops only after a finished programming cycle
    assert_fall_needs_done_R5: assert property (@(posedge clk)
        disable iff (!por_n) ($fell(prot_on) && $past(por_n)) |-> $past(prog_done));

    // R2: protection rises only on a consumed (unstored) load
    assert_rise_on_cmd_R2: assert property (@(posedge clk)
        disable iff (!por_n) $rose(prot_on) |-> ($past(ld_valid) && !$past(ld_permit)));

    // R9: ordinary reset leaves protection untouched
    assert_reset_keeps_R9: assert property (@(posedge clk)
        disable iff (!por_n) !rst_n |=> $stable(prot_on));
endmodule

bind wprot_cmd_seq wprot_cmd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .ld_valid    (ld_valid),
    .prog_done   (prog_done),
    .ld_permit   (ld_permit),
    .prog_start  (prog_start),
    .prot_on     (prot_on),
    .window_open (window_open),
    .erase_busy  (erase_busy)
);

// File: tb/wprot_cmd_seq_bench.sv
`timescale 1ns/100ps
module wprot_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [14:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        prog_done = 1'b0;
    logic        ld_permit;
    logic        prog_start;
    logic        prot_on;

    integer total = 0;
    integer bad = 0;
    integer cycles = 0;
    string  phase = "R10";
    logic   last_permit;
    logic   started = 1'b0;

    // behavioural reference model
    logic [14:0] sa [6];
    logic [7:0]  sd [6];
    integer m_pos = 0;
    logic   m_prot = 1'b0, m_win = 1'b0, m_pend = 1'b0, m_start = 1'b0;
    logic   n_start, was_pend, was_win;

    wprot_cmd_seq u_wprot_cmd_seq (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_data(ld_data), .prog_done(prog_done),
        .ld_permit(ld_permit), .prog_start(prog_start), .prot_on(prot_on)
    );

    always #2.5 clk = ~clk;

    initial begin
        sa[0] = 15'h5555; sd[0] = 8'hAA;
        sa[1] = 15'h2AAA; sd[1] = 8'h55;
        sa[2] = 15'h5555; sd[2] = 8'h80;
        sa[3] = 15'h5555; sd[3] = 8'hAA;
        sa[4] = 15'h2AAA; sd[4] = 8'h55;
        sa[5] = 15'h5555; sd[5] = 8'h20;
    end

    function automatic logic pair(input logic [14:0] a, input logic [7:0] d);
        return (ld_addr == a) && (ld_data == d);
    endfunction

    // model update on each edge
    always @(posedge clk) begin
        if (!por_n) begin
            m_prot = 0; m_pos = 0; m_win = 0; m_pend = 0; m_start = 0;
        end else if (!rst_n) begin
            m_pos = 0; m_win = 0; m_pend = 0; m_start = 0;
        end else begin
            n_start = 0; was_pend = m_pend; was_win = m_win;
            if (ld_valid && !m_win && !m_pend) begin
                if (m_pos == 2 && pair(15'h5555, 8'hA0)) begin
                    m_pos = 0; m_prot = 1; m_win = 1;
                end else if (pair(sa[m_pos], sd[m_pos])) begin
                    if (m_pos == 5) begin m_pos = 0; m_pend = 1; n_start = 1; end
                    else m_pos = m_pos + 1;
                end else if (pair(sa[0], sd[0])) m_pos = 1;
                else m_pos = 0;
            end
            if (prog_done) begin
                if (was_pend) begin m_prot = 0; m_pend = 0; end
                if (was_win) m_win = 0;
            end
            m_start = n_start;
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        logic is_cmd, exp_perm;
        cycles = cycles + 1;
        if (started && rst_n && por_n) begin
            is_cmd = (m_pos == 2 && pair(15'h5555, 8'hA0)) || pair(sa[m_pos], sd[m_pos])
                     || pair(sa[0], sd[0]);
            exp_perm = ld_valid && !m_pend && (m_win || (!is_cmd && !m_prot));
            chk(ld_permit === exp_perm, {phase, " model permit"}, ld_permit, exp_perm);
            chk(prot_on === m_prot, {phase, " model prot"}, prot_on, m_prot);
            chk(prog_start === m_start, {phase, " model start"}, prog_start, m_start);
        end
    end

    task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        last_permit = ld_permit;
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic pdone();
        @(posedge clk); #1 prog_done = 1'b1;
        @(posedge clk); #1 prog_done = 1'b0;
    endtask

    task automatic unlock();
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
    endtask

    // watchdog
    initial begin
        #400000;
        bad = bad + 1; total = total + 1;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1; rst_n = 1'b1; started = 1'b1;
        @(negedge clk);
        chk(prot_on === 1'b0, "R10 reset prot", prot_on, 1'b0);

        phase = "R1";
        wr(15'h0100, 8'h12);
        chk(last_permit === 1'b1, "R1 plain write", last_permit, 1'b1);

        phase = "R8";
        wr(15'h5555, 8'hAA);
        chk(last_permit === 1'b0, "R8 key consumed", last_permit, 1'b0);
        phase = "R7";
        wr(15'h0123, 8'h33);
        chk(last_permit === 1'b1, "R7 break stored unprotected", last_permit, 1'b1);

        phase = "R11";
        wr(15'h5555, 8'hAA);
        wr(15'h5555, 8'hAA);
        chk(last_permit === 1'b0, "R7 restart key consumed", last_permit, 1'b0);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk(last_permit === 1'b0, "R2 lock write consumed", last_permit, 1'b0);
        chk(prot_on === 1'b1, "R11 unlock sets prot", prot_on, 1'b1);

        phase = "R3";
        wr(15'h4000, 8'h01);
        chk(last_permit === 1'b1, "R3 window load", last_permit, 1'b1);
        wr(15'h5555, 8'hAA);
        chk(last_permit === 1'b1, "R3 key inside window stored", last_permit, 1'b1);
        pdone();
        phase = "R4";
        wr(15'h4002, 8'h03);
        chk(last_permit === 1'b0, "R4 protected plain write", last_permit, 1'b0);

        phase = "R7";
        wr(15'h5555, 8'hAA); wr(15'h0010, 8'h99);
        chk(last_permit === 1'b0, "R7 break discarded protected", last_permit, 1'b0);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0); wr(15'h0001, 8'h07);
        chk(last_permit === 1'b0, "R7 aborted unlock gives no window", last_permit, 1'b0);

        phase = "R9";
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(prot_on === 1'b1, "R9 prot survives reset", prot_on, 1'b1);
        wr(15'h5555, 8'hA0); wr(15'h0002, 8'h08);
        chk(last_permit === 1'b0, "R9 matcher cleared", last_permit, 1'b0);
        unlock();
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        wr(15'h0003, 8'h09);
        chk(last_permit === 1'b0, "R9 window cleared", last_permit, 1'b0);

        phase = "R2";
        unlock();
        chk(prot_on === 1'b1, "R2 unlock keeps prot", prot_on, 1'b1);
        wr(15'h7FFF, 8'h5A);
        chk(last_permit === 1'b1, "R2 page load allowed", last_permit, 1'b1);
        pdone();

        phase = "R5";
        for (int i = 0; i < 6; i++) wr(sa[i], sd[i]);
        chk(last_permit === 1'b0, "R5 erase keys consumed", last_permit, 1'b0);
        @(negedge clk);
        chk(prog_start === 1'b1, "R5 start pulse", prog_start, 1'b1);
        chk(prot_on === 1'b1, "R5 prot held until done", prot_on, 1'b1);
        phase = "R6";
        wr(15'h0004, 8'h0A);
        chk(last_permit === 1'b0, "R6 busy blocks", last_permit, 1'b0);
        chk(prog_start === 1'b0, "R5 start single cycle", prog_start, 1'b0);
        pdone();
        @(negedge clk);
        chk(prot_on === 1'b0, "R5 prot cleared", prot_on, 1'b0);
        phase = "R1";
        wr(15'h0005, 8'h0B);
        chk(last_permit === 1'b1, "R1 write after erase", last_permit, 1'b1);

        phase = "R10";
        unlock(); pdone();
        @(posedge clk); #1 por_n = 1'b0;
        @(posedge clk); #1 por_n = 1'b1;
        @(negedge clk);
        chk(prot_on === 1'b0, "R10 power-on clears prot", prot_on, 1'b0);
        wr(15'h0006, 8'h0C);
        chk(last_permit === 1'b1, "R10 writes open", last_permit, 1'b1);

        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule